// File: doc/BRIEF.md
# Programmable Serial Bit Clock Generator

This block produces the bit clock of a serial transmit port from a fast master clock. A programmable integer divider sets the bit clock period. Software can instead pass through a bit clock that arrives on an input pin, and can choose the bit clock edge on which transmit data is shifted. Each shift edge is marked by a one-cycle strobe in the master clock domain, so a neighbouring serializer never has to use the bit clock as a clock.

The divide ratio can be changed while the clock runs. A new ratio is held back until the divider reaches the end of its current period. A two-bit one-shot command makes a single bit period one master cycle longer or shorter, which lets the bit rate track a drifting reference. Status flags in the single control word show when a ratio change or an adjustment has not yet finished. Software must not start a second change of the same kind while the first is still in progress.

Top module: `bclk_gen`

## Requirements
- R1: After reset the control word reads 0x0000_0500. The ratio field [4:0] is 0, the source bit [8] is 1 (internal), the shift-edge bit [9] is 0, the mode bit [10] is 1, the adjust field [13:12] is 0, and the status bits [16] ratio-busy, [17] adjust-busy and [18] busy are all 0.
- R2: With the internal source, a ratio field value N (0 to 31) gives a bit clock period of exactly N+1 master clock cycles between successive shift strobes.
- R3: For N+1 of two or more, the bit clock is high for ceil((N+1)/2) master cycles of each period, so an odd ratio puts its extra cycle in the high phase.
- R4: At N = 0 with the internal source, bit clock output follows the master clock and the shift strobe is high in every master cycle.
- R5: With edge bit 0, the shift strobe is high in the master cycle in which the bit clock becomes high. With edge bit 1, it is high in the cycle in which the bit clock becomes low.
- R6: With source bit 0, the bit clock output copies the external bit clock input delayed by two master clock cycles. The shift strobe is high on the cycle of that copy's rising edge (edge bit 0) or its falling edge (edge bit 1).
- R7: A written ratio reads back at once and sets ratio-busy [16]. The new ratio takes effect only where the current period ends, so the period that was running completes at its old length. Ratio-busy clears on the master cycle in which the new period begins.
- R8: A ratio field written while ratio-busy is set is ignored. The ratio field keeps its earlier value.
- R9: Adjust code 01 in [13:12] makes the next full bit period one master cycle longer. Code 10 makes it one cycle shorter. Adjust-busy [17] is set from the write until that adjusted period has ended.
- R10: Adjust codes 00 and 11 have no effect. Code 10 has no effect when the ratio field is 0. An adjust code written while adjust-busy is set is ignored.
- R11: Status bit [18] is high exactly when bit [16] or bit [17] is high.
- R12: The mode bit [10] stores the written value, reads back unchanged, and drives the `tx_async_o` output.
- R13: The adjust field is write-only and always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released on the clock |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Control word and status read-back |
| ext_bclk_i | input | 1 | External bit clock input |
| bclk_o | output | 1 | Bit clock output |
| shift_stb_o | output | 1 | One-master-cycle strobe at each shift edge |
| tx_async_o | output | 1 | Stored transmit/receive mode bit |

## Verification
The hardest case to produce is a control write that lands while a change is still waiting for the end of a long period. The bench first runs the slowest ratio so that the divider is in the middle of a 32-cycle period. It then writes a new ratio and, straight after, a conflicting one, and measures strobe-to-strobe gaps to show that the old period completed and that the second write was dropped. The adjustment checks work the same way: they time strobe gaps on both sides of the adjusted period, including a second adjust code written immediately behind the first.

// File: rtl/bclk_pkg.sv
`timescale 1ns/1ps
package bclk_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned RATIO_LSB = 0;
  localparam int unsigned SRC_BIT   = 8;
  localparam int unsigned POL_BIT   = 9;
  localparam int unsigned MODE_BIT  = 10;
  localparam int unsigned ADJ_LSB   = 12;
  localparam int unsigned RBUSY_BIT = 16;
  localparam int unsigned ABUSY_BIT = 17;
  localparam int unsigned BUSY_BIT  = 18;

  typedef enum logic [1:0] {
    ADJ_NONE  = 2'b00,
    ADJ_LONG  = 2'b01,
    ADJ_SHORT = 2'b10,
    ADJ_NOP   = 2'b11
  } adj_code_e;
endpackage

// File: rtl/bclk_ctrl_regs.sv
`timescale 1ns/1ps
module bclk_ctrl_regs
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [DIV_W-1:0] ratio_act_i,
  input  logic             adj_take_i,
  input  logic             adj_run_i,
  output logic [DIV_W-1:0] ratio_sw_o,
  output logic             src_int_o,
  output logic             pol_fall_o,
  output logic             mode_o,
  output logic             adj_pend_o,
  output logic             adj_len_o,
  output logic             rbusy_o,
  output logic             abusy_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic [DIV_W-1:0] ratio_q, ratio_d, wr_ratio;
  logic             src_q, pol_q, mode_q;
  logic             adj_pend_q, adj_pend_d, adj_len_q, adj_len_d;
  logic             ratio_we, adj_set, rbusy, abusy;
  adj_code_e        wr_adj;

  // next-state logic
  always_comb begin
    wr_ratio   = wr_data_i[RATIO_LSB +: DIV_W];
    wr_adj     = adj_code_e'(wr_data_i[ADJ_LSB +: 2]);
    rbusy      = (ratio_q != ratio_act_i);
    abusy      = adj_pend_q | adj_run_i;
    ratio_we   = wr_en_i & ~rbusy;
    ratio_d    = ratio_we ? wr_ratio : ratio_q;
    adj_set    = wr_en_i & ~abusy &
                 ((wr_adj == ADJ_LONG) | ((wr_adj == ADJ_SHORT) & (ratio_d != '0)));
    adj_len_d  = adj_set ? (wr_adj == ADJ_LONG) : adj_len_q;
    adj_pend_d = adj_pend_q;
    if (adj_set)         adj_pend_d = 1'b1;
    else if (adj_take_i) adj_pend_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q    <= '0;
      src_q      <= 1'b1;
      pol_q      <= 1'b0;
      mode_q     <= 1'b1;
      adj_pend_q <= 1'b0;
      adj_len_q  <= 1'b0;
    end else begin
      if (ratio_we) ratio_q <= ratio_d;
      if (wr_en_i) begin
        src_q  <= wr_data_i[SRC_BIT];
        pol_q  <= wr_data_i[POL_BIT];
        mode_q <= wr_data_i[MODE_BIT];
      end
      if (adj_set) adj_len_q <= adj_len_d;
      adj_pend_q <= adj_pend_d;
    end
  end

  // read-back word; adjust field stays zero
  always_comb begin
    rd_data_o                         = '0;
    rd_data_o[RATIO_LSB +: DIV_W]     = ratio_q;
    rd_data_o[SRC_BIT]                = src_q;
    rd_data_o[POL_BIT]                = pol_q;
    rd_data_o[MODE_BIT]               = mode_q;
    rd_data_o[RBUSY_BIT]              = rbusy;
    rd_data_o[ABUSY_BIT]              = abusy;
    rd_data_o[BUSY_BIT]               = rbusy | abusy;
  end

  assign ratio_sw_o = ratio_q;
  assign src_int_o  = src_q;
  assign pol_fall_o = pol_q;
  assign mode_o     = mode_q;
  assign adj_pend_o = adj_pend_q;
  assign adj_len_o  = adj_len_q;
  assign rbusy_o    = rbusy;
  assign abusy_o    = abusy;
endmodule

// File: rtl/bclk_divider.sv
`timescale 1ns/1ps
module bclk_divider #(
  parameter int unsigned DIV_W = 5,
  localparam int unsigned PER_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] ratio_sw_i,
  input  logic             adj_pend_i,
  input  logic             adj_len_i,
  output logic [DIV_W-1:0] ratio_act_o,
  output logic             adj_take_o,
  output logic             adj_run_o,
  output logic             term_o,
  output logic [PER_W-1:0] cnt_o,
  output logic [PER_W-1:0] per_o,
  output logic             div1_o,
  output logic             bclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] cnt_q, cnt_d, per_q, per_d, base, hi_d;
  logic [DIV_W-1:0] ratio_q, ratio_d;
  logic             run_q, run_d, take, term;
  logic             bclk_q, bclk_d, rise_q, rise_d, fall_q, fall_d;

  // next-state logic: reload only at the terminal count
  always_comb begin
    term    = (cnt_q == per_q - ONE);
    base    = {1'b0, ratio_sw_i} + ONE;
    cnt_d   = term ? '0 : cnt_q + ONE;
    ratio_d = term ? ratio_sw_i : ratio_q;
    per_d   = per_q;
    run_d   = run_q;
    take    = 1'b0;
    if (term) begin
      run_d = adj_pend_i;
      take  = adj_pend_i;
      if (adj_pend_i && adj_len_i)         per_d = base + ONE;
      else if (adj_pend_i && (base > ONE)) per_d = base - ONE;
      else                                 per_d = base;
    end
    hi_d   = (per_d + ONE) >> 1;
    bclk_d = (cnt_d < hi_d);
    rise_d = (cnt_d == '0);
    fall_d = (per_d == ONE) | (cnt_d == hi_d);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_q   <= ONE;
      ratio_q <= '0;
      run_q   <= 1'b0;
      bclk_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      ratio_q <= ratio_d;
      run_q   <= run_d;
      bclk_q  <= bclk_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign ratio_act_o = ratio_q;
  assign adj_take_o  = take;
  assign adj_run_o   = run_q;
  assign term_o      = term;
  assign cnt_o       = cnt_q;
  assign per_o       = per_q;
  assign div1_o      = (per_q == ONE);
  assign bclk_o      = bclk_q;
  assign rise_o      = rise_q;
  assign fall_o      = fall_q;
endmodule

// File: rtl/bclk_out_sel.sv
`timescale 1ns/1ps
module bclk_out_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_int_i,
  input  logic pol_fall_i,
  input  logic div1_i,
  input  logic bclk_int_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic ext_bclk_i,
  output logic bclk_o,
  output logic stb_o
);
  logic [SYNC_STAGES-1:0] ext_q;
  logic                   ext_prev_q, ext_s;

  // synchronizer plus one edge-detect stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q      <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      ext_q      <= {ext_q[SYNC_STAGES-2:0], ext_bclk_i};
      ext_prev_q <= ext_q[SYNC_STAGES-1];
    end
  end

  assign ext_s = ext_q[SYNC_STAGES-1];

  always_comb begin
    if (src_int_i) begin
      bclk_o = div1_i ? clk_i : bclk_int_i;
      stb_o  = pol_fall_i ? fall_i : rise_i;
    end else begin
      bclk_o = ext_s;
      stb_o  = pol_fall_i ? (ext_prev_q & ~ext_s) : (ext_s & ~ext_prev_q);
    end
  end
endmodule

// File: rtl/bclk_gen.sv
`timescale 1ns/1ps
module bclk_gen
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W       = 5,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PER_W      = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             ext_bclk_i,
  output logic             bclk_o,
  output logic             shift_stb_o,
  output logic             tx_async_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [DIV_W-1:0] ratio_sw, ratio_act;
  logic             src_int, pol_fall, adj_pend, adj_len, adj_take, adj_run;
  logic             rbusy, abusy, term, div1, bclk_int, rise, fall;
  logic [PER_W-1:0] cnt, per;

  // asynchronous assert, clocked release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bclk_ctrl_regs #(.DIV_W(DIV_W)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ratio_act_i(ratio_act), .adj_take_i(adj_take), .adj_run_i(adj_run),
    .ratio_sw_o(ratio_sw), .src_int_o(src_int), .pol_fall_o(pol_fall),
    .mode_o(tx_async_o), .adj_pend_o(adj_pend), .adj_len_o(adj_len),
    .rbusy_o(rbusy), .abusy_o(abusy), .rd_data_o(rd_data_o)
  );

  bclk_divider #(.DIV_W(DIV_W)) div_i (
    .clk_i(clk_i), .rst_ni(rst_n), .ratio_sw_i(ratio_sw), .adj_pend_i(adj_pend),
    .adj_len_i(adj_len), .ratio_act_o(ratio_act), .adj_take_o(adj_take),
    .adj_run_o(adj_run), .term_o(term), .cnt_o(cnt), .per_o(per),
    .div1_o(div1), .bclk_o(bclk_int), .rise_o(rise), .fall_o(fall)
  );

  bclk_out_sel #(.SYNC_STAGES(SYNC_STAGES)) out_i (
    .clk_i(clk_i), .rst_ni(rst_n), .src_int_i(src_int), .pol_fall_i(pol_fall),
    .div1_i(div1), .bclk_int_i(bclk_int), .rise_i(rise), .fall_i(fall),
    .ext_bclk_i(ext_bclk_i), .bclk_o(bclk_o), .stb_o(shift_stb_o)
  );
endmodule

// File: rtl/bclk_gen_chk.sv
`timescale 1ns/1ps
module bclk_gen_chk #(
  parameter int unsigned DIV_W = 5,
  localparam int unsigned PER_W = DIV_W + 1
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic             rbusy,
  input logic             abusy,
  input logic [DIV_W-1:0] ratio_sw,
  input logic [DIV_W-1:0] ratio_act,
  input logic             term,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] per,
  input logic             adj_pend,
  input logic             adj_run,
  input logic             adj_len
);
  localparam logic [PER_W-1:0] PMAX = PER_W'((1 << DIV_W) + 1);

  // R2: counter stays inside the active period
  a_r2_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt < per);

  // R9: period never leaves the legal adjusted range
  a_r9_period_range: assert property (@(posedge clk_i) disable iff (!rst_n)
    (per != '0) && (per <= PMAX));

  // R7: active ratio only moves after a terminal count
  a_r7_load_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(ratio_act) |-> $past(term));

  // R8: ratio field frozen when written during ratio-busy
  a_r8_ratio_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && rbusy) |=> $stable(ratio_sw));

  // R10: adjust direction frozen when written during adjust-busy
  a_r10_adj_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && abusy) |=> $stable(adj_len));

  // R9: an adjusted period only starts from a pending command
  a_r9_run_from_pending: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(adj_run) |-> $past(adj_pend));
endmodule

bind bclk_gen bclk_gen_chk #(.DIV_W(DIV_W)) chk_i (
  .clk_i(clk_i), .rst_n(rst_n), .wr_en_i(wr_en_i), .rbusy(rbusy), .abusy(abusy),
  .ratio_sw(ratio_sw), .ratio_act(ratio_act), .term(term), .cnt(cnt), .per(per),
  .adj_pend(adj_pend), .adj_run(adj_run), .adj_len(adj_len)
);

// File: tb/bclk_gen_tb_top.sv
`timescale 1ns/1ps
module bclk_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic        ext_bclk_i;
  logic        bclk_o;
  logic        shift_stb_o;
  logic        tx_async_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  bclk_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .ext_bclk_i(ext_bclk_i), .bclk_o(bclk_o),
    .shift_stb_o(shift_stb_o), .tx_async_o(tx_async_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] mk(input int ratio, input bit src, input bit pol,
                                     input bit mode, input logic [1:0] adj);
    logic [31:0] w;
    w        = '0;
    w[4:0]   = ratio[4:0];
    w[8]     = src;
    w[9]     = pol;
    w[10]    = mode;
    w[13:12] = adj;
    return w;
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = w;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((rd_data_o[16] | rd_data_o[17]) && n < 500) begin
      @(negedge clk_i);
      n++;
    end
    if (n >= 500) chk(1'b0, "idle timeout", n, 0);
  endtask

  // waits for the next strobe; returns its cycle and the bit clock one sample earlier
  task automatic wait_stb(output int t, output logic prv);
    int n = 0;
    logic last;
    do begin
      last = bclk_o;
      @(negedge clk_i);
      n++;
    end while (!shift_stb_o && n < 500);
    if (n >= 500) chk(1'b0, "strobe timeout", n, 0);
    t   = cyc;
    prv = last;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
    end
  end

  initial begin
    int   t0, t1, t2, t3, hi;
    logic p;
    rst_ni     = 1'b0;
    wr_en_i    = 1'b0;
    wr_data_i  = '0;
    ext_bclk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R1 reset state, R13 adjust field empty
    chk(rd_data_o == 32'h0000_0500, "R1 reset word", rd_data_o, 32'h500);
    chk(tx_async_o == 1'b1, "R1 mode output", tx_async_o, 1);

    // R4 divide-by-1
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(bclk_o == 1'b0 && shift_stb_o == 1'b1, "R4 low half / strobe", {bclk_o, shift_stb_o}, 2'b01);
      @(posedge clk_i); #1;
      chk(bclk_o == 1'b1, "R4 high half", bclk_o, 1);
    end

    // R2 R3 R5 sweep, rising-edge shift
    for (int n = 1; n < 32; n++) begin
      wr(mk(n, 1, 0, 1, 2'b00));
      chk(rd_data_o[16] == 1'b1 && rd_data_o[18] == 1'b1, "R7 R11 busy after ratio write",
          rd_data_o[18:16], 3'b101);
      wait_idle();
      chk(rd_data_o[18] == 1'b0, "R11 busy clear", rd_data_o[18], 0);
      wait_stb(t0, p);
      wait_stb(t1, p);
      chk(t1 - t0 == n + 1, "R2 period rising", t1 - t0, n + 1);
      chk(bclk_o == 1'b1 && p == 1'b0, "R5 strobe on rise", {p, bclk_o}, 2'b01);
      hi = 1;
      while (hi < 40) begin
        @(negedge clk_i);
        if (!bclk_o) break;
        hi++;
      end
      chk(hi == (n + 2) / 2, "R3 high phase", hi, (n + 2) / 2);
    end

    // R2 R5 sweep, falling-edge shift
    for (int n = 1; n < 32; n++) begin
      wr(mk(n, 1, 1, 1, 2'b00));
      wait_idle();
      wait_stb(t0, p);
      wait_stb(t1, p);
      chk(t1 - t0 == n + 1, "R2 period falling", t1 - t0, n + 1);
      chk(bclk_o == 1'b0 && p == 1'b1, "R5 strobe on fall", {p, bclk_o}, 2'b10);
    end

    // R7 R8: ratio change held to the end of a 32-cycle period
    wr(mk(31, 1, 0, 1, 2'b00));
    wait_idle();
    wait_stb(t0, p);
    wr(mk(3, 1, 0, 1, 2'b00));
    chk(rd_data_o[4:0] == 5'd3 && rd_data_o[16], "R7 readback and busy", rd_data_o[16:0], 32'h10003);
    wr(mk(5, 1, 0, 1, 2'b00));
    chk(rd_data_o[4:0] == 5'd3, "R8 write during busy ignored", rd_data_o[4:0], 3);
    wait_stb(t1, p);
    chk(t1 - t0 == 32, "R7 old period completes", t1 - t0, 32);
    chk(rd_data_o[16] == 1'b0, "R7 busy clears at boundary", rd_data_o[16], 0);
    wait_stb(t2, p);
    chk(t2 - t1 == 4, "R7 R8 new period", t2 - t1, 4);

    // R9 lengthen and shorten on ratio 7
    wr(mk(7, 1, 0, 1, 2'b00));
    wait_idle();
    for (int m = 0; m < 2; m++) begin
      logic [1:0] code;
      int         adj_per;
      code    = (m == 0) ? 2'b01 : 2'b10;
      adj_per = (m == 0) ? 9 : 7;
      wait_stb(t0, p);
      wr(mk(7, 1, 0, 1, code));
      chk(rd_data_o[17] && rd_data_o[18], "R9 R11 adjust busy", rd_data_o[18:16], 3'b110);
      chk(rd_data_o[13:12] == 2'b00, "R13 adjust reads zero", rd_data_o[13:12], 0);
      wait_stb(t1, p);
      chk(t1 - t0 == 8, "R9 period before adjust", t1 - t0, 8);
      chk(rd_data_o[17] == 1'b1, "R9 busy during adjusted period", rd_data_o[17], 1);
      wait_stb(t2, p);
      chk(t2 - t1 == adj_per, "R9 adjusted period", t2 - t1, adj_per);
      chk(rd_data_o[17] == 1'b0, "R9 busy clears after adjust", rd_data_o[17], 0);
      wait_stb(t3, p);
      chk(t3 - t2 == 8, "R9 period after adjust", t3 - t2, 8);
    end

    // R10 inert codes and second command while busy
    for (int m = 0; m < 2; m++) begin
      wr(mk(7, 1, 0, 1, (m == 0) ? 2'b11 : 2'b00));
      chk(rd_data_o[17] == 1'b0, "R10 inert code", rd_data_o[17], 0);
      wait_stb(t0, p);
      wait_stb(t1, p);
      chk(t1 - t0 == 8, "R10 period unchanged", t1 - t0, 8);
    end
    wait_stb(t0, p);
    wr(mk(7, 1, 0, 1, 2'b01));
    wr(mk(7, 1, 0, 1, 2'b10));
    wait_stb(t1, p);
    wait_stb(t2, p);
    wait_stb(t3, p);
    chk(t1 - t0 == 8 && t2 - t1 == 9 && t3 - t2 == 8, "R10 second adjust ignored",
        t3 - t2, 8);
    wr(mk(0, 1, 0, 1, 2'b00));
    wait_idle();
    wr(mk(0, 1, 0, 1, 2'b10));
    chk(rd_data_o[17] == 1'b0, "R10 shorten at divide-by-1 ignored", rd_data_o[17], 0);

    // R6 external source, both edge selections
    for (int pol = 0; pol < 2; pol++) begin
      wr(mk(0, 0, pol[0], 1, 2'b00));
      repeat (4) @(negedge clk_i);
      for (int k = 0; k < 4; k++) begin
        logic nv;
        nv         = ~ext_bclk_i;
        ext_bclk_i = nv;
        @(negedge clk_i);
        chk(bclk_o == ~nv, "R6 one cycle: old level", bclk_o, ~nv);
        @(negedge clk_i);
        chk(bclk_o == nv, "R6 two cycles: new level", bclk_o, nv);
        chk(shift_stb_o == (pol == 0 ? nv : ~nv), "R6 external strobe", shift_stb_o,
            (pol == 0 ? nv : ~nv));
        @(negedge clk_i);
        chk(shift_stb_o == 1'b0, "R6 strobe one cycle", shift_stb_o, 0);
      end
    end

    // R12 mode bit
    wr(mk(0, 1, 0, 0, 2'b00));
    chk(rd_data_o[10] == 1'b0 && tx_async_o == 1'b0, "R12 mode cleared", rd_data_o[10], 0);
    wr(mk(0, 1, 0, 1, 2'b00));
    chk(rd_data_o[10] == 1'b1 && tx_async_o == 1'b1, "R12 mode set", rd_data_o[10], 1);

    done = 1'b1;
    summary();
  end
endmodule